// File: doc/BRIEF.md
# EEPROM Access Controller with Write Interlock

This block sits between a small processor core and an on-chip byte-wide nonvolatile data array. Software reaches it through four byte registers on a simple synchronous bus: the address low byte, the address high byte, the data byte and a three-bit control byte. The control byte holds an arm bit, a write-busy bit and a read-request bit. The array itself is modelled inside the block as a synchronous memory.

A write is protected by an interlock. Software first sets the arm bit. Hardware clears that bit again after a short window. The write-busy bit must be set inside that window, or nothing happens. Once a write has started, the busy bit stays high for a parameterised number of cycles and then drops. Software polls that bit to learn when the write is done. A read request fetches the addressed byte into the data register. The block drives a CPU stall output for a short, fixed number of cycles whenever a read or write starts. Software that changes the address or data register during a write spoils that write. The block then stores the erased value in the target byte and raises a corruption flag.

Top module: `eeprom_ctl`

## Requirements
- R1: A control write with bit 1 set starts a write only while the arm bit is set and no access is in progress. Starting a write clears the arm bit. Without the arm bit set, such a write leaves the control bits, the stall output and the array unchanged.
- R2: The arm bit reads 1 for ARM_WINDOW (default 4) cycles after the edge that sets it and is then cleared by hardware. A write request on any of the ARM_WINDOW following edges starts a write. A request on a later edge has no effect.
- R3: A control write sets the arm bit only if the same write has bit 1 at 0. A control write of 0x06 leaves the arm bit clear.
- R4: The write-busy bit reads 1 for exactly WRITE_CYCLES cycles after the start edge and then clears by itself. When it clears, the data byte latched at the start has been committed to the address latched at the start.
- R5: A write start drives stall_o high for WRITE_STALL (default 2) cycles.
- R6: A control write with bit 0 set, when the block is idle, sets the read-request bit and drives stall_o high for READ_STALL (default 4) cycles. At the end of that time the request bit clears and the data register holds the array byte at the current address.
- R7: A bus write to the address or data registers while the busy bit is 1 spoils the write in progress. The target byte is then stored as 0xFF and corrupt_o rises at the end of the write. corrupt_o stays high until the next write starts.
- R8: The address low byte (select 0) and high byte (select 1) are written independently. The high byte keeps ADDR_W-8 bits and reads back zero-extended.
- R9: A read request made while a write is busy is ignored. The read-request bit stays 0, stall_o stays low and the data register is not changed.
- R10: Register selects are 0 address low, 1 address high, 2 data and 3 control. The control byte reads live as {5'b0, arm, busy, read-request} in bits 2, 1 and 0.
- R11: Reset clears the control bits, the timers, stall_o and corrupt_o. Reset leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 2 | Register select |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Read data of the selected register |
| stall_o | output | 1 | CPU stall request |
| corrupt_o | output | 1 | Last write was spoiled by a register update |

## Verification
Write requests are issued after arm-to-request gaps of every length from zero up to beyond the window. This shows whether the window closes on the correct edge and not one cycle early or late. Combined arm-and-request writes, requests with no arm, and read requests during a busy write separate the interlock paths from the normal start path. Register updates in the middle of a write show that the spoiled byte is replaced, while untouched writes keep their data. Random addresses and data are read back against a bench model of the array, which separates correct address latching and commit timing from mere busy-bit timing.

// File: rtl/eectl_pkg.sv
package eectl_pkg;
  typedef enum logic [1:0] {
    REG_ADDR_LO = 2'd0,
    REG_ADDR_HI = 2'd1,
    REG_DATA    = 2'd2,
    REG_CTRL    = 2'd3
  } reg_sel_e;

  localparam int BIT_ARM = 2;
  localparam int BIT_WE  = 1;
  localparam int BIT_RE  = 0;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/eectl_down_timer.sv
module eectl_down_timer #(
  parameter int MAX = 4,
  parameter int W   = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         clr_i,
  output logic         active_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign active_o = (cnt_q != '0);
  assign last_o   = (cnt_q == W'(1));
endmodule

// File: rtl/eectl_array.sv
module eectl_array #(
  parameter int ADDR_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  logic [7:0] mem [DEPTH];

  // no reset: contents survive a block reset
  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/eeprom_ctl.sv
module eeprom_ctl
  import eectl_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int WRITE_CYCLES = 20,
  parameter int ARM_WINDOW   = 4,
  parameter int WRITE_STALL  = 2,
  parameter int READ_STALL   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       stall_o,
  output logic       corrupt_o
);
  localparam int HI_W      = ADDR_W - 8;
  localparam int STALL_MAX = (WRITE_STALL > READ_STALL) ? WRITE_STALL : READ_STALL;
  localparam int ARM_W     = $clog2(ARM_WINDOW + 1);
  localparam int WT_W      = $clog2(WRITE_CYCLES + 1);
  localparam int ST_W      = $clog2(STALL_MAX + 1);

  reg_sel_e sel;
  assign sel = reg_sel_e'(sel_i);

  logic [7:0]        addr_lo_q, data_q, tgt_data_q;
  logic [HI_W-1:0]   addr_hi_q;
  logic [ADDR_W-1:0] addr, tgt_addr_q;
  logic              rd_pend_q, spoil_q, corrupt_q;
  logic              armed, busy, wt_last, stall_last;
  logic              ctrl_wr, arm_set, write_start, read_start, rd_done;
  logic              spoil_hit, arr_we;
  logic [7:0]        arr_wdata, arr_rdata;

  assign addr    = {addr_hi_q, addr_lo_q};
  assign ctrl_wr = wr_i && (sel == REG_CTRL);
  // arming needs the write-enable bit at zero in the same write
  assign arm_set     = ctrl_wr && wdata_i[BIT_ARM] && !wdata_i[BIT_WE];
  assign write_start = ctrl_wr && wdata_i[BIT_WE] && armed && !busy && !rd_pend_q;
  assign read_start  = ctrl_wr && wdata_i[BIT_RE] && !busy && !write_start && !rd_pend_q;
  assign rd_done     = rd_pend_q && stall_last;
  assign spoil_hit   = busy && wr_i && (sel != REG_CTRL);

  eectl_down_timer #(.MAX(ARM_WINDOW), .W(ARM_W)) u_arm (
    .clk_i, .rst_ni,
    .load_i(arm_set), .load_val_i(ARM_W'(ARM_WINDOW)), .clr_i(write_start),
    .active_o(armed), .last_o()
  );

  eectl_down_timer #(.MAX(WRITE_CYCLES), .W(WT_W)) u_wtime (
    .clk_i, .rst_ni,
    .load_i(write_start), .load_val_i(WT_W'(WRITE_CYCLES)), .clr_i(1'b0),
    .active_o(busy), .last_o(wt_last)
  );

  eectl_down_timer #(.MAX(STALL_MAX), .W(ST_W)) u_stall (
    .clk_i, .rst_ni,
    .load_i(write_start || read_start),
    .load_val_i(write_start ? ST_W'(WRITE_STALL) : ST_W'(READ_STALL)),
    .clr_i(1'b0),
    .active_o(stall_o), .last_o(stall_last)
  );

  assign arr_we    = busy && wt_last;
  assign arr_wdata = (spoil_q || spoil_hit) ? ERASED_BYTE : tgt_data_q;

  eectl_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i,
    .we_i(arr_we), .waddr_i(tgt_addr_q), .wdata_i(arr_wdata),
    .raddr_i(addr), .rdata_o(arr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_lo_q  <= '0;
      addr_hi_q  <= '0;
      data_q     <= '0;
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
      rd_pend_q  <= 1'b0;
      spoil_q    <= 1'b0;
      corrupt_q  <= 1'b0;
    end else begin
      if (wr_i && sel == REG_ADDR_LO) addr_lo_q <= wdata_i;
      if (wr_i && sel == REG_ADDR_HI) addr_hi_q <= wdata_i[HI_W-1:0];
      if (rd_done)                         data_q <= arr_rdata;
      else if (wr_i && sel == REG_DATA)    data_q <= wdata_i;

      if (read_start)   rd_pend_q <= 1'b1;
      else if (rd_done) rd_pend_q <= 1'b0;

      if (write_start) begin
        tgt_addr_q <= addr;
        tgt_data_q <= data_q;
        spoil_q    <= 1'b0;
        corrupt_q  <= 1'b0;
      end else begin
        if (spoil_hit) spoil_q <= 1'b1;
        if (arr_we && (spoil_q || spoil_hit)) corrupt_q <= 1'b1;
      end
    end
  end

  assign corrupt_o = corrupt_q;

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      REG_ADDR_LO: rdata_o = addr_lo_q;
      REG_ADDR_HI: rdata_o[HI_W-1:0] = addr_hi_q;
      REG_DATA:    rdata_o = data_q;
      REG_CTRL: begin
        rdata_o[BIT_ARM] = armed;
        rdata_o[BIT_WE]  = busy;
        rdata_o[BIT_RE]  = rd_pend_q;
      end
      default:     rdata_o = '0;
    endcase
  end

  assert_start_needs_arm_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(armed));

  assert_arm_needs_we0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[BIT_ARM] && wdata_i[BIT_WE] && !armed) |=> !armed);

  assert_commit_at_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> $past(arr_we));

  assert_write_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> stall_o);

  assert_read_stalls_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pend_q |-> stall_o);

  assert_no_read_while_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !rd_pend_q);
endmodule

// File: tb/tb_eeprom_ctl.sv
`timescale 1ns/1ps
module tb_eeprom_ctl;
  import eectl_pkg::*;

  localparam int AW = 9;
  localparam int WC = 20;
  localparam int AWIN = 4;
  localparam int WS = 2;
  localparam int RS = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] sel_i = '0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       stall_o, corrupt_o;

  int  n_tests = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  logic [7:0] ref_mem [1 << AW];
  int         written [64];
  int         n_written = 0;

  always #2.5 clk = ~clk;

  eeprom_ctl #(.ADDR_W(AW), .WRITE_CYCLES(WC), .ARM_WINDOW(AWIN),
               .WRITE_STALL(WS), .READ_STALL(RS)) dut (
    .clk_i(clk), .rst_ni, .sel_i, .wr_i, .wdata_i, .rdata_o, .stall_o, .corrupt_o
  );

  function automatic bit accept_expected(input int gap);
    return gap < AWIN;
  endfunction

  function automatic logic [7:0] ctrl_expected(input bit arm, input bit we, input bit re);
    return {5'b0, arm, we, re};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] s, input logic [7:0] d);
    sel_i = s; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [7:0] d);
    sel_i = s;
    #1;
    d = rdata_o;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_addr(input int a);
    bus_wr(REG_ADDR_LO, a[7:0]);
    bus_wr(REG_ADDR_HI, 8'(a >> 8));
  endtask

  task automatic start_write(input int a, input logic [7:0] d, input int gap);
    set_addr(a);
    bus_wr(REG_DATA, d);
    bus_wr(REG_CTRL, 8'h04);
    idle(gap);
    bus_wr(REG_CTRL, 8'h02);
  endtask

  task automatic read_byte(input int a, output logic [7:0] d);
    set_addr(a);
    bus_wr(REG_CTRL, 8'h01);
    idle(RS);
    rd_reg(REG_DATA, d);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): run did not end, actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd7099));
    @(negedge clk);
    idle(2);
    rst_ni = 1'b1;
    idle(1);

    // reset state
    rd_reg(REG_CTRL, v); chk("R11", "ctrl after reset", v, 8'h00);
    chk("R11", "stall after reset", stall_o, 1'b0);
    chk("R11", "corrupt after reset", corrupt_o, 1'b0);

    // address bytes
    bus_wr(REG_ADDR_LO, 8'h5A);
    bus_wr(REG_ADDR_HI, 8'hFF);
    rd_reg(REG_ADDR_LO, v); chk("R8", "addr low", v, 8'h5A);
    rd_reg(REG_ADDR_HI, v); chk("R8", "addr high zero-extended", v, 8'h01);
    bus_wr(REG_ADDR_LO, 8'h11);
    rd_reg(REG_ADDR_HI, v); chk("R8", "high kept on low write", v, 8'h01);

    // arm window expiry
    bus_wr(REG_CTRL, 8'h04);
    rd_reg(REG_CTRL, v); chk("R10", "arm readback", v, ctrl_expected(1, 0, 0));
    idle(AWIN - 1);
    rd_reg(REG_CTRL, v); chk("R2", "arm still set at window end", v, 8'h04);
    idle(1);
    rd_reg(REG_CTRL, v); chk("R2", "arm self-cleared", v, 8'h00);

    // write request without arm
    bus_wr(REG_CTRL, 8'h02);
    rd_reg(REG_CTRL, v); chk("R1", "unarmed request ignored", v, 8'h00);
    chk("R1", "no stall when unarmed", stall_o, 1'b0);

    // arm together with write enable
    bus_wr(REG_CTRL, 8'h06);
    rd_reg(REG_CTRL, v); chk("R3", "arm with we=1 rejected", v, 8'h00);
    bus_wr(REG_CTRL, 8'h02);
    rd_reg(REG_CTRL, v); chk("R3", "no write after rejected arm", v, 8'h00);

    // directed good write, stall and busy timing
    start_write(3, 8'hA5, 0);
    rd_reg(REG_CTRL, v); chk("R1", "busy set, arm consumed", v, ctrl_expected(0, 1, 0));
    chk("R5", "stall cycle 1", stall_o, 1'b1);
    idle(WS - 1); chk("R5", "stall last cycle", stall_o, 1'b1);
    idle(1);      chk("R5", "stall released", stall_o, 1'b0);
    idle(WC - WS - 1);
    rd_reg(REG_CTRL, v); chk("R4", "busy at last cycle", v, 8'h02);
    idle(1);
    rd_reg(REG_CTRL, v); chk("R4", "busy cleared", v, 8'h00);
    ref_mem[3] = 8'hA5; written[n_written++] = 3;

    // read timing
    set_addr(3);
    bus_wr(REG_CTRL, 8'h01);
    rd_reg(REG_CTRL, v); chk("R6", "read request bit", v, ctrl_expected(0, 0, 1));
    chk("R6", "read stall start", stall_o, 1'b1);
    idle(RS - 1);
    chk("R6", "read stall last", stall_o, 1'b1);
    idle(1);
    chk("R6", "read stall released", stall_o, 1'b0);
    rd_reg(REG_CTRL, v); chk("R6", "read request cleared", v, 8'h00);
    rd_reg(REG_DATA, v); chk("R6", "read data", v, 8'hA5);

    // window boundary: last accepted gap and first rejected gap
    start_write(10, 8'h3E, AWIN - 1);
    rd_reg(REG_CTRL, v); chk("R2", "request on last window edge", v, 8'h02);
    idle(WC);
    ref_mem[10] = 8'h3E; written[n_written++] = 10;
    start_write(10, 8'hC1, AWIN);
    rd_reg(REG_CTRL, v); chk("R2", "request after window", v, 8'h00);
    read_byte(10, v); chk("R2", "array untouched after late request", v, 8'h3E);

    // read during busy write
    start_write(20, 8'h77, 1);
    idle(WS);
    bus_wr(REG_CTRL, 8'h01);
    rd_reg(REG_CTRL, v); chk("R9", "read ignored while busy", v, 8'h02);
    chk("R9", "no stall for ignored read", stall_o, 1'b0);
    rd_reg(REG_DATA, v); chk("R9", "data reg unchanged", v, 8'h77);
    idle(WC);
    ref_mem[20] = 8'h77; written[n_written++] = 20;

    // spoiled write
    start_write(7, 8'h3C, 0);
    idle(3);
    bus_wr(REG_DATA, 8'h99);
    chk("R7", "corrupt low during write", corrupt_o, 1'b0);
    idle(WC);
    chk("R7", "corrupt raised", corrupt_o, 1'b1);
    read_byte(7, v); chk("R7", "spoiled byte erased", v, 8'hFF);
    ref_mem[7] = 8'hFF; written[n_written++] = 7;
    start_write(8, 8'h42, 0);
    chk("R7", "corrupt cleared on new start", corrupt_o, 1'b0);
    idle(WC);
    read_byte(8, v); chk("R7", "clean write kept", v, 8'h42);
    ref_mem[8] = 8'h42; written[n_written++] = 8;

    // reset keeps the array
    start_write(9, 8'h10, 0);
    idle(2);
    bus_wr(REG_ADDR_LO, 8'h00);
    idle(WC);
    chk("R7", "corrupt before reset", corrupt_o, 1'b1);
    do_reset();
    chk("R11", "corrupt cleared by reset", corrupt_o, 1'b0);
    rd_reg(REG_CTRL, v); chk("R11", "ctrl cleared by reset", v, 8'h00);
    read_byte(3, v); chk("R11", "array kept over reset", v, 8'hA5);

    // random writes with random arm gaps, read back against the model
    for (int i = 0; i < 30; i++) begin
      int a, g, k;
      logic [7:0] d;
      bit exp_acc;
      a = int'($urandom % (1 << AW));
      d = 8'($urandom);
      g = int'($urandom % 7);
      exp_acc = accept_expected(g);
      start_write(a, d, g);
      rd_reg(REG_CTRL, v);
      chk(exp_acc ? "R1" : "R2", "random request accept", v, exp_acc ? 8'h02 : 8'h00);
      if (exp_acc) begin
        idle(WC);
        rd_reg(REG_CTRL, v); chk("R4", "random busy cleared", v, 8'h00);
        ref_mem[a] = d;
        if (n_written < 64) written[n_written++] = a;
      end
      k = written[int'($urandom % n_written)];
      read_byte(k, v); chk("R6", "random readback", v, ref_mem[k]);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule